// File: doc/BRIEF.md
# Acknowledge Polling Write-Completion Sequencer

This block sits on the master side of a two-wire serial bus. It tells the host when a serial memory has finished its internally timed write. It does not wait out a fixed worst-case delay. While the memory is busy with its write cycle it answers nothing, so the block probes it again and again. Each probe is a start condition followed by the device control byte with the direction bit cleared. The block then looks at the ninth clock. If SDA is high there, nobody acknowledged, and the block goes straight into a repeated start and sends the same byte again. If SDA is low, the memory has finished.

The host pulses `start_poll_i` as soon as the stop condition of its write command has gone out. The block needs no settling delay before the first probe. On an acknowledge it raises `ready_o` and parks the bus with SCL held low and no stop condition. The host may then carry on with its next operation in the same transaction, or it can pulse `stop_req_i` to close the bus. An optional attempt limit ends a poll that has gone on too long: the block sends a stop and raises `timeout_o`. A parameter divides the system clock to set the SCL rate. The bus lines are open-drain and are driven through output-enable pins.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, both output enables are low, so the lines are released. `busy_o`, `ready_o` and `timeout_o` are all low.
- R2: When `start_poll_i` is pulsed while idle, the first start condition (SDA falling while SCL is high) appears within 4*CLK_DIV+6 clock cycles, with no settling delay.
- R3: Every attempt is a start condition followed by nine SCL pulses. The first eight carry the byte {dev_addr, 1'b0}, most significant bit first. The ninth pulse is the acknowledge slot, and in it SDA is released.
- R4: An attempt whose acknowledge slot reads SDA high is followed directly by a repeated start and the same control byte. No stop condition comes between attempts.
- R5: When the acknowledge slot reads SDA low, `ready_o` rises and `busy_o` falls. SCL is then held low with SDA released, and no stop condition is sent while `ready_o` is high.
- R6: A `stop_req_i` pulse while `ready_o` is high produces one stop condition (SDA rising while SCL is high). After it, the block is idle with both lines released.
- R7: With `max_tries_i` = N and N not zero, the N-th consecutive attempt without acknowledge ends the poll. The block sends one stop and then sets `timeout_o`, which stays high until the next accepted `start_poll_i`. With N = 0, polling has no limit.
- R8: SDA changes while SCL is high only to form a start or stop condition. No start or stop appears inside a byte.
- R9: Every SCL high pulse of a byte lasts exactly 2*CLK_DIV clock cycles.
- R10: `start_poll_i` is ignored while a poll is running or while `ready_o` is high. `stop_req_i` is ignored unless `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_poll_i | input | 1 | Pulse: a write's stop has gone out; begin polling |
| stop_req_i | input | 1 | Pulse: send a stop while ready |
| dev_addr_i | input | 7 | Device address, latched when a poll starts |
| max_tries_i | input | TRY_W | Attempt limit, latched when a poll starts; 0 means unlimited |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Poll or stop in progress |
| ready_o | output | 1 | Device acknowledged; bus held |
| timeout_o | output | 1 | Last poll hit its attempt limit |

## Verification
The assertions assume three things about the inputs: the host pulses `start_poll_i` and `stop_req_i` for a single cycle, the device pulls SDA low only within the acknowledge slot, and no other master drives SCL. The bench's device model drives SDA only from the falling SCL edge after the eighth bit until the falling edge after the ninth. It never touches SCL. The random part varies the address, the number of refused attempts and the attempt limit. It also pulses the host controls at moments when they must be ignored.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } ap_cmd_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_START,
    ENG_BYTE,
    ENG_STOP
  } ap_eng_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_START,
    PS_CTRL,
    PS_HOLD,
    PS_STOP
  } ap_poll_e;
endpackage

// File: rtl/ap_tick_gen.sv
module ap_tick_gen #(
  parameter int unsigned CLK_DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0)); // R9
endmodule

// File: rtl/ap_bit_engine.sv
module ap_bit_engine
  import ap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_valid_i,
  input  ap_cmd_e    cmd_i,
  input  logic [7:0] byte_i,
  input  logic       sda_i,
  output logic       active_o,
  output logic       done_o,
  output logic       ack_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_BITS);

  ap_eng_e    st_q;
  logic [1:0] phase_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       scl_oe_q, sda_oe_q, ack_q, done_q;
  logic [1:0] sda_sync_q;
  logic       sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_sync_q <= 2'b11;
    else         sda_sync_q <= {sda_sync_q[0], sda_i};
  end
  assign sda_s = sda_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ENG_IDLE;
      phase_q  <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      ack_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ENG_IDLE) begin
        if (cmd_valid_i) begin
          sh_q    <= byte_i;
          phase_q <= '0;
          bit_q   <= '0;
          unique case (cmd_i)
            CMD_START: st_q <= ENG_START;
            CMD_BYTE:  st_q <= ENG_BYTE;
            default:   st_q <= ENG_STOP;
          endcase
        end
      end else if (tick_i) begin
        phase_q <= phase_q + 1'b1;
        unique case (phase_q)
          2'd0: begin
            // SCL is low here (or idle-high with SDA already released)
            if (st_q == ENG_START)     sda_oe_q <= 1'b0;
            else if (st_q == ENG_STOP) sda_oe_q <= 1'b1;
            else                       sda_oe_q <= (bit_q < ACK_BIT) ? ~sh_q[7] : 1'b0;
          end
          2'd1: scl_oe_q <= 1'b0;
          2'd2: begin
            if (st_q == ENG_START)     sda_oe_q <= 1'b1;
            else if (st_q == ENG_STOP) sda_oe_q <= 1'b0;
            else if (bit_q == ACK_BIT) ack_q    <= ~sda_s;
          end
          default: begin
            if (st_q != ENG_STOP) scl_oe_q <= 1'b1;
            if (st_q == ENG_BYTE && bit_q != ACK_BIT) begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end else begin
              st_q   <= ENG_IDLE;
              done_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign active_o = (st_q != ENG_IDLE);
  assign done_o   = done_q;
  assign ack_o    = ack_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_q && !$past(scl_oe_q) && (sda_oe_q != $past(sda_oe_q)))
      |-> ($past(st_q) == ENG_START || $past(st_q) == ENG_STOP)); // R8
  AST_CMD_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> (st_q == ENG_IDLE)); // R3
  AST_ACK_SLOT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENG_BYTE && bit_q == ACK_BIT && !scl_oe_q) |-> !sda_oe_q); // R3
endmodule

// File: rtl/ap_poll_fsm.sv
module ap_poll_fsm
  import ap_pkg::*;
#(
  parameter int unsigned TRY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_poll_i,
  input  logic             stop_req_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [TRY_W-1:0] max_tries_i,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  output logic             cmd_valid_o,
  output ap_cmd_e          cmd_o,
  output logic [7:0]       cmd_byte_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             timeout_o
);
  ap_poll_e         st_q;
  logic [6:0]       addr_q;
  logic [TRY_W-1:0] lim_q, tries_q;
  logic             cmd_valid_q, tmo_pend_q, timeout_q;
  ap_cmd_e          cmd_q;
  logic             at_limit;

  assign at_limit = (lim_q != '0) && (tries_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PS_IDLE;
      addr_q      <= '0;
      lim_q       <= '0;
      tries_q     <= '0;
      cmd_valid_q <= 1'b0;
      cmd_q       <= CMD_START;
      tmo_pend_q  <= 1'b0;
      timeout_q   <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      unique case (st_q)
        PS_IDLE: if (start_poll_i) begin
          addr_q      <= dev_addr_i;
          lim_q       <= max_tries_i;
          tries_q     <= '0;
          tmo_pend_q  <= 1'b0;
          timeout_q   <= 1'b0;
          cmd_q       <= CMD_START;
          cmd_valid_q <= 1'b1;
          st_q        <= PS_START;
        end
        PS_START: if (eng_done_i) begin
          cmd_q       <= CMD_BYTE;
          cmd_valid_q <= 1'b1;
          tries_q     <= tries_q + 1'b1;
          st_q        <= PS_CTRL;
        end
        PS_CTRL: if (eng_done_i) begin
          if (eng_ack_i) begin
            st_q <= PS_HOLD;
          end else if (at_limit) begin
            cmd_q       <= CMD_STOP;
            cmd_valid_q <= 1'b1;
            tmo_pend_q  <= 1'b1;
            st_q        <= PS_STOP;
          end else begin
            cmd_q       <= CMD_START;
            cmd_valid_q <= 1'b1;
            st_q        <= PS_START;
          end
        end
        PS_HOLD: if (stop_req_i) begin
          cmd_q       <= CMD_STOP;
          cmd_valid_q <= 1'b1;
          st_q        <= PS_STOP;
        end
        default: if (eng_done_i) begin
          timeout_q <= tmo_pend_q;
          st_q      <= PS_IDLE;
        end
      endcase
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;
  assign cmd_byte_o  = {addr_q, 1'b0};
  assign busy_o      = (st_q != PS_IDLE) && (st_q != PS_HOLD);
  assign ready_o     = (st_q == PS_HOLD);
  assign timeout_o   = timeout_q;

  AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_q) |-> (lim_q != '0 && tries_q == lim_q)); // R7
  AST_TRIES_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q != '0) |-> (tries_q <= lim_q)); // R7
  AST_NO_STOP_ON_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_CTRL && eng_done_i && !eng_ack_i && !at_limit)
      |=> (cmd_valid_q && cmd_q == CMD_START)); // R4
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ap_pkg::*;
#(
  parameter int unsigned CLK_DIV = 125,
  parameter int unsigned TRY_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_poll_i,
  input  logic             stop_req_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [TRY_W-1:0] max_tries_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             timeout_o
);
  logic       tick, eng_active, eng_done, eng_ack, cmd_valid;
  ap_cmd_e    cmd;
  logic [7:0] cmd_byte;

  ap_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (eng_active),
    .tick_o(tick)
  );

  ap_bit_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cmd_valid_i(cmd_valid),
    .cmd_i      (cmd),
    .byte_i     (cmd_byte),
    .sda_i      (sda_i),
    .active_o   (eng_active),
    .done_o     (eng_done),
    .ack_o      (eng_ack),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  ap_poll_fsm #(.TRY_W(TRY_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_poll_i(start_poll_i),
    .stop_req_i  (stop_req_i),
    .dev_addr_i  (dev_addr_i),
    .max_tries_i (max_tries_i),
    .eng_done_i  (eng_done),
    .eng_ack_i   (eng_ack),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .cmd_byte_o  (cmd_byte),
    .busy_o      (busy_o),
    .ready_o     (ready_o),
    .timeout_o   (timeout_o)
  );

  AST_HOLD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (scl_oe_o && !sda_oe_o)); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ready_o) |-> (!scl_oe_o && !sda_oe_o)); // R1
  AST_ENGINE_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ready_o) |-> !eng_active); // R6
endmodule

// File: tb/ack_poll_seq_bench.sv
module ack_poll_seq_bench;
  localparam int D = 4;
  localparam int TW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_poll_i = 1'b0, stop_req_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic [TW-1:0] max_tries_i = '0;
  logic sda_i, scl_oe_o, sda_oe_o, busy_o, ready_o, timeout_o;
  logic sl_drive = 1'b0;

  assign sda_i = ~(sda_oe_o | sl_drive);

  ack_poll_seq #(.CLK_DIV(D), .TRY_W(TW)) u_ack_poll_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_poll_i(start_poll_i), .stop_req_i(stop_req_i),
    .dev_addr_i(dev_addr_i), .max_tries_i(max_tries_i), .sda_i(sda_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .ready_o(ready_o),
    .timeout_o(timeout_o)
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  int checks = 0, errors = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // device model
  logic scl_p = 1'b1, sda_p = 1'b1;
  int bitcnt = 0, n_starts = 0, n_stops = 0, n_bytes = 0, bad_byte = 0;
  int mid_err = 0, hi_bad = 0, hi_start = 0, first_start = -1, busy_left = 0;
  logic in_byte = 1'b0;
  logic [7:0] shin = '0, exp_byte = '0;
  logic [6:0] sl_addr = '0;

  always @(negedge clk_i) begin
    logic scl, sda;
    scl = ~scl_oe_o;
    sda = ~(sda_oe_o | sl_drive);
    if (rst_ni) begin
      if (scl && scl_p && sda_p && !sda) begin
        n_starts++;
        if (first_start < 0) first_start = cyc;
        if (bitcnt != 0) mid_err++;
        bitcnt = 0; in_byte = 1'b1;
      end else if (scl && scl_p && !sda_p && sda) begin
        n_stops++;
        if (bitcnt != 0) mid_err++;
        in_byte = 1'b0;
      end else if (scl && !scl_p) begin
        hi_start = cyc;
        if (in_byte) begin
          if (bitcnt < 8) shin = {shin[6:0], sda};
          bitcnt++;
        end
      end else if (!scl && scl_p && in_byte && bitcnt > 0) begin
        if (cyc - hi_start != 2 * D) hi_bad++;
        if (bitcnt == 8) begin
          n_bytes++;
          if (shin != exp_byte) bad_byte++;
          if (shin[7:1] == sl_addr && !shin[0] && busy_left == 0) sl_drive = 1'b1;
          else if (busy_left > 0) busy_left--;
        end else if (bitcnt == 9) begin
          sl_drive = 1'b0; bitcnt = 0; in_byte = 1'b0;
        end
      end
    end
    scl_p = scl;
    sda_p = ~(sda_oe_o | sl_drive);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_attempts(input bit match, input int k, input int lim);
    if (!match) return lim;
    if (lim == 0) return k + 1;
    return (k + 1 < lim) ? k + 1 : lim;
  endfunction

  function automatic bit exp_ready(input bit match, input int k, input int lim);
    return match && (lim == 0 || k < lim);
  endfunction

  task automatic run_poll(input logic [6:0] addr, input bit match, input int k, input int lim,
                          input bit disturb);
    int t0, guard, att, st0;
    bit rdy;
    n_starts = 0; n_stops = 0; n_bytes = 0; bad_byte = 0; mid_err = 0; hi_bad = 0;
    first_start = -1;
    exp_byte = {addr, 1'b0};
    sl_addr = match ? addr : (addr ^ 7'h01);
    busy_left = k;
    @(negedge clk_i);
    dev_addr_i = addr; max_tries_i = TW'(lim); start_poll_i = 1'b1; t0 = cyc;
    @(negedge clk_i); start_poll_i = 1'b0;
    @(negedge clk_i);
    chk("R7 timeout cleared on new poll", int'(timeout_o), 0);
    guard = 0;
    while (!ready_o && !(timeout_o && !busy_o) && guard < 20000) begin
      @(negedge clk_i); guard++;
      if (disturb && n_bytes == 1 && busy_o && start_poll_i == 1'b0 && guard < 20000) begin
        dev_addr_i = ~addr; start_poll_i = 1'b1; stop_req_i = 1'b1;
        @(negedge clk_i); start_poll_i = 1'b0; stop_req_i = 1'b0; disturb = 1'b0;
      end
    end
    att = exp_attempts(match, k, lim);
    rdy = exp_ready(match, k, lim);
    chk("R2 first start delay ok", int'(first_start >= 0 && first_start - t0 <= 4 * D + 6), 1);
    chk("R3 control bytes correct", bad_byte, 0);
    chk("R4 attempt count", n_bytes, att);
    chk("R4 starts per attempt", n_starts, att);
    chk("R5 ready on ack", int'(ready_o), int'(rdy));
    chk("R7 timeout at limit", int'(timeout_o), int'(!rdy));
    chk("R8 no start/stop inside byte", mid_err, 0);
    chk("R9 scl high width", hi_bad, 0);
    if (rdy) begin
      chk("R5 no stop while ready", n_stops, 0);
      chk("R5 scl held low, busy low", int'(scl_oe_o && !sda_oe_o && !busy_o), 1);
      st0 = n_starts;
      start_poll_i = 1'b1; @(negedge clk_i); start_poll_i = 1'b0;
      repeat (12 * D) @(negedge clk_i);
      chk("R10 start_poll ignored when ready", int'(ready_o) + (n_starts - st0), 1);
      stop_req_i = 1'b1; @(negedge clk_i); stop_req_i = 1'b0;
      guard = 0;
      while ((busy_o || ready_o) && guard < 2000) begin @(negedge clk_i); guard++; end
      chk("R6 one stop after request", n_stops, 1);
      chk("R6 lines released", int'(scl_oe_o) + int'(sda_oe_o), 0);
    end else begin
      chk("R7 one stop on timeout", n_stops, 1);
      st0 = n_starts + n_stops;
      stop_req_i = 1'b1; @(negedge clk_i); stop_req_i = 1'b0;
      repeat (8 * D) @(negedge clk_i);
      chk("R10 stop_req ignored when not ready", n_starts + n_stops - st0, 0);
      chk("R7 timeout held", int'(timeout_o && !busy_o), 1);
    end
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected below 150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 reset lines released", int'(scl_oe_o) + int'(sda_oe_o), 0);
    chk("R1 reset flags low", int'(busy_o) + int'(ready_o) + int'(timeout_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 stop_req in idle no bus activity", int'(scl_oe_o) + int'(sda_oe_o), 0);
    run_poll(7'h50, 1'b1, 0, 1, 1'b0);
    run_poll(7'h2A, 1'b1, 3, 3, 1'b0);
    run_poll(7'h51, 1'b1, 2, 3, 1'b1);
    run_poll(7'h7F, 1'b1, 20, 0, 1'b0);
    run_poll(7'h00, 1'b0, 0, 5, 1'b0);
    for (int i = 0; i < 10; i++) begin
      logic [6:0] a;
      int k, lim;
      bit m;
      a = 7'($urandom);
      k = int'($urandom % 6);
      lim = int'($urandom % 8);
      m = (lim == 0) ? 1'b1 : 1'($urandom % 4 != 0);
      run_poll(a, m, k, lim, 1'($urandom % 2));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule